// File: doc/BRIEF.md
# Multidrop Address-Filtering Serial Receiver

This block receives characters from a multidrop serial line where many stations share one wire. In place of a parity bit, each character carries a tag bit that says whether it is an address (tag 1) or a payload byte (tag 0). The receiver oversamples the line 16 times per bit, driven by a sample-rate tick from outside. It decodes every character it sees and checks each one for framing errors and line breaks. It places accepted characters in a four-entry holding queue that a CPU drains with a read strobe.

The enable input does not stop decoding. It only controls which characters are kept. While the receiver is disabled, only address-tagged characters are stored, so a station can sleep through traffic meant for other stations. Once software has recognised its own address and set the enable, every character is stored. The tag bit is handed to software in the status slot that would otherwise hold a parity error. No parity is computed anywhere.

Top module: `mdr_rx`

## Requirements
- R1: After reset, `rx_ready`, `overrun` and `brk` are all low.
- R2: The character is framed in this order: a low start bit, then N data bits with the least significant bit first, then the tag bit, then one or two high stop bits. N is 5, 6, 7 or 8 for `len_sel` values 0, 1, 2 and 3. `rd_data` holds the data right-justified, with its unused upper bits at zero.
- R3: While `rx_en` is 1, every character is stored whatever its tag, and `rd_tag` presents the received tag bit.
- R4: While `rx_en` is 0, a character with tag 1 is stored. A character with tag 0 is discarded and leaves `rx_ready` unchanged.
- R5: The queue holds 4 characters and returns them in arrival order. `rx_ready` is high exactly while the queue is non-empty. A one-cycle `rd` pulse removes the head entry.
- R6: A character that would be stored while the queue is full is discarded, and the sticky `overrun` output is set. The entries already held are unchanged. A one-cycle `clr_err` pulse clears `overrun`.
- R7: A character that the filter discards never sets `overrun`, even when the queue is full.
- R8: `rd_ferr` is 1 when any stop bit of that character was sampled low (the first or the second stop bit when `two_stop` is 1), and 0 otherwise.
- R9: A break is a character in which the data bits, the tag bit and every stop bit are all low. On a break, `brk` goes high. The character is handled as data 0, tag 0, framing error 1. `brk` stays high until the line returns high. No new character starts before then.
- R10: `len_sel` and `two_stop` are captured only when a start bit is detected. Changing them during a character has no effect on that character.
- R11: A low pulse on `rxd` shorter than half a bit time is rejected as a false start and stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | 1: keep all characters; 0: keep address-tagged characters only |
| len_sel | input | 2 | Data-bit count select, 0..3 gives 5..8 bits |
| two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| rd | input | 1 | Pop the head entry of the queue |
| clr_err | input | 1 | Clear the overrun flag |
| rx_ready | output | 1 | Queue not empty |
| rd_data | output | 8 | Data field of the head entry |
| rd_tag | output | 1 | Tag bit of the head entry (1 = address) |
| rd_ferr | output | 1 | Framing-error flag of the head entry |
| overrun | output | 1 | Sticky overrun flag |
| brk | output | 1 | Break in progress |

## Verification
Address-tagged and data-tagged characters are sent with the enable both high and low. This separates the storing path from the dropping path, and it shows whether the tag bit reaches the status slot instead of being treated as parity. Characters of 5, 6 and 8 data bits with one and two stop bits, including a length change in mid-character, show whether the configuration is captured only at the start bit and whether the data is justified correctly. A full queue is hit once with a character that must be kept and once with one that must be dropped, which separates a true overrun from a filtered discard. Frames with bad stop bits, an all-low break and a short glitch separate a framing error, a break and a rejected false start.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

    localparam int DW = 8;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          tag;
        logic          ferr;
    } mdr_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_TAG,
        S_STOP,
        S_HOLD
    } mdr_state_t;

    function automatic logic [3:0] nbits_of(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    function automatic logic [DW-1:0] justify(input logic [DW-1:0] sh, input logic [3:0] n);
        return sh >> (4'(DW) - n);
    endfunction

endpackage

// File: rtl/mdr_sync.sv
module mdr_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            dout <= 1'b1;
        end else begin
            s1   <= din;
            dout <= s1;
        end
    end
endmodule

// File: rtl/mdr_frame_rx.sv
module mdr_frame_rx
    import mdr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_two,
    output logic       done,
    output mdr_entry_t ent,
    output logic       brk
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] HALF_C = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

    mdr_state_t    st;
    logic [CW-1:0] cnt;
    logic [3:0]    nb;
    logic [3:0]    idx;
    logic          two;
    logic [DW-1:0] sh;
    logic          tag_r;
    logic          allz;
    logic          bad;
    logic          mid;

    assign mid = tick && (cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            cnt   <= '0;
            nb    <= 4'd8;
            idx   <= '0;
            two   <= 1'b0;
            sh    <= '0;
            tag_r <= 1'b0;
            allz  <= 1'b0;
            bad   <= 1'b0;
            done  <= 1'b0;
            ent   <= '0;
            brk   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick && st != S_IDLE && st != S_HOLD && st != S_START)
                cnt <= cnt + 1'b1;
            case (st)
                S_IDLE: begin
                    if (tick && !rx_s) begin
                        st   <= S_START;
                        cnt  <= '0;
                        nb   <= nbits_of(cfg_sel);
                        two  <= cfg_two;
                        sh   <= '0;
                        allz <= 1'b1;
                        bad  <= 1'b0;
                        idx  <= '0;
                    end
                end
                S_START: begin
                    if (tick) begin
                        if (cnt == HALF_C) begin
                            cnt <= '0;
                            st  <= rx_s ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (mid) begin
                        sh <= {rx_s, sh[DW-1:1]};
                        if (rx_s) allz <= 1'b0;
                        if (idx == nb - 4'd1) begin
                            idx <= '0;
                            st  <= S_TAG;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                end
                S_TAG: begin
                    if (mid) begin
                        tag_r <= rx_s;
                        if (rx_s) allz <= 1'b0;
                        st <= S_STOP;
                    end
                end
                S_STOP: begin
                    if (mid) begin
                        if (two && idx == 4'd0) begin
                            idx <= 4'd1;
                            if (!rx_s) bad <= 1'b1;
                            if (rx_s) allz <= 1'b0;
                        end else begin
                            done     <= 1'b1;
                            ent.data <= justify(sh, nb);
                            ent.tag  <= tag_r;
                            ent.ferr <= bad | ~rx_s;
                            brk      <= allz & ~rx_s;
                            st       <= rx_s ? S_IDLE : S_HOLD;
                        end
                    end
                end
                S_HOLD: begin
                    if (rx_s) begin
                        brk <= 1'b0;
                        st  <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdr_fifo.sv
module mdr_fifo
    import mdr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  mdr_entry_t din,
    input  logic       rd,
    output mdr_entry_t dout,
    output logic       empty,
    output logic       full
);
    localparam int AW = $clog2(DEPTH);

    mdr_entry_t        mem [DEPTH];
    logic [AW-1:0]     wp;
    logic [AW-1:0]     rp;
    logic [AW:0]       cnt;
    logic              do_wr;
    logic              do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/mdr_rx.sv
module mdr_rx
    import mdr_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rxd,
    input  logic          rx_en,
    input  logic [1:0]    len_sel,
    input  logic          two_stop,
    input  logic          rd,
    input  logic          clr_err,
    output logic          rx_ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_tag,
    output logic          rd_ferr,
    output logic          overrun,
    output logic          brk
);
    logic       rx_s;
    logic       frm_done;
    mdr_entry_t frm_ent;
    mdr_entry_t head;
    logic       q_empty;
    logic       q_full;
    logic       keep;

    mdr_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    mdr_frame_rx #(.OVS(OVS)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rx_s    (rx_s),
        .cfg_sel (len_sel),
        .cfg_two (two_stop),
        .done    (frm_done),
        .ent     (frm_ent),
        .brk     (brk)
    );

    assign keep = frm_done && (rx_en || frm_ent.tag);

    mdr_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (keep),
        .din   (frm_ent),
        .rd    (rd),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst)                 overrun <= 1'b0;
        else if (keep && q_full) overrun <= 1'b1;
        else if (clr_err)        overrun <= 1'b0;
    end

    assign rx_ready = !q_empty;
    assign rd_data  = head.data;
    assign rd_tag   = head.tag;
    assign rd_ferr  = head.ferr;
endmodule

// File: rtl/mdr_rx_chk.sv
module mdr_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rxd,
    input logic       rd,
    input logic       clr_err,
    input logic       rx_ready,
    input logic [7:0] rd_data,
    input logic       rd_tag,
    input logic       overrun,
    input logic       brk,
    input logic       done
);
    // R6: overrun holds until cleared
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun && !clr_err |=> overrun);

    // R7: an empty queue cannot overflow on the next edge
    a_r7_no_ovr_when_empty: assert property (@(posedge clk) disable iff (rst)
        !rx_ready && !overrun |=> !overrun);

    // R5: the head entry stays put until popped
    a_r5_head_stable: assert property (@(posedge clk) disable iff (rst)
        rx_ready && !rd |=> rx_ready && $stable(rd_data) && $stable(rd_tag));

    // R5: data appears only after a completed character
    a_r5_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(done));

    // R9: break clears once the line has been high for three samples
    a_r9_brk_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rxd, 1) && $past(rxd, 2) && $past(rxd, 3) |-> !brk);
endmodule

bind mdr_rx mdr_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rxd      (rxd),
    .rd       (rd),
    .clr_err  (clr_err),
    .rx_ready (rx_ready),
    .rd_data  (rd_data),
    .rd_tag   (rd_tag),
    .overrun  (overrun),
    .brk      (brk),
    .done     (frm_done)
);

// File: tb/mdr_rx_bench.sv
module mdr_rx_bench;
    localparam int BIT = 32;   // tick every 2 clocks, 16 ticks per bit

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic       two_stop = 1'b0;
    logic       rd = 1'b0;
    logic       clr_err = 1'b0;
    logic       rx_ready;
    logic [7:0] rd_data;
    logic       rd_tag;
    logic       rd_ferr;
    logic       overrun;
    logic       brk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) tick <= ~tick;

    mdr_rx u_mdr_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_en(rx_en),
        .len_sel(len_sel), .two_stop(two_stop), .rd(rd), .clr_err(clr_err),
        .rx_ready(rx_ready), .rd_data(rd_data), .rd_tag(rd_tag),
        .rd_ferr(rd_ferr), .overrun(overrun), .brk(brk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic b, input int n);
        rxd = b;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] d, input logic tg, input int nb, input int ns,
                        input logic s0, input logic s1, input bit chg, input logic [1:0] nsel);
        hold(1'b0, BIT);
        if (chg) begin
            len_sel  = nsel;
            two_stop = ~two_stop;
        end
        for (int i = 0; i < nb; i++) hold(d[i], BIT);
        hold(tg, BIT);
        hold(s0, BIT);
        if (ns == 2) hold(s1, BIT);
        hold(1'b1, 2 * BIT);
    endtask

    task automatic sendc(input logic [7:0] d, input logic tg);
        send(d, tg, 8, 1, 1'b1, 1'b1, 1'b0, 2'd0);
    endtask

    task automatic pop(input string req, input logic [7:0] ed, input logic et, input logic ef);
        chk({req, " ready"}, 32'(rx_ready), 32'd1);
        chk({req, " data"}, 32'(rd_data), 32'(ed));
        chk({req, " tag"}, 32'(rd_tag), 32'(et));
        chk({req, " ferr"}, 32'(rd_ferr), 32'(ef));
        rd = 1'b1;
        @(posedge clk); #1;
        rd = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(rx_ready), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 brk", 32'(brk), 32'd0);
    endtask

    task automatic t_format();
        rx_en = 1'b1; len_sel = 2'd3; two_stop = 1'b0;
        sendc(8'hA5, 1'b0);
        pop("R2 8bit", 8'hA5, 1'b0, 1'b0);
        len_sel = 2'd0;
        send(8'hF5, 1'b1, 5, 1, 1'b1, 1'b1, 1'b0, 2'd0);
        pop("R2 5bit", 8'h15, 1'b1, 1'b0);
        len_sel = 2'd1; two_stop = 1'b1;
        send(8'h2B, 1'b0, 6, 2, 1'b1, 1'b1, 1'b0, 2'd0);
        pop("R2 6bit two stop", 8'h2B, 1'b0, 1'b0);
        chk("R2 empty", 32'(rx_ready), 32'd0);
        len_sel = 2'd3; two_stop = 1'b0;
    endtask

    task automatic t_enabled();
        rx_en = 1'b1;
        sendc(8'h3C, 1'b1);
        sendc(8'hC3, 1'b0);
        pop("R3 addr", 8'h3C, 1'b1, 1'b0);
        pop("R3 data", 8'hC3, 1'b0, 1'b0);
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        sendc(8'h11, 1'b0);
        chk("R4 data dropped", 32'(rx_ready), 32'd0);
        sendc(8'h22, 1'b1);
        sendc(8'h33, 1'b0);
        pop("R4 addr kept", 8'h22, 1'b1, 1'b0);
        chk("R4 trailing data dropped", 32'(rx_ready), 32'd0);
        rx_en = 1'b1;
    endtask

    task automatic t_fifo();
        rx_en = 1'b1;
        for (int i = 0; i < 4; i++) sendc(8'(8'h40 + i), 1'(i % 2));
        for (int i = 0; i < 4; i++) pop("R5 order", 8'(8'h40 + i), 1'(i % 2), 1'b0);
        chk("R5 empty after drain", 32'(rx_ready), 32'd0);
    endtask

    task automatic t_overrun();
        rx_en = 1'b1;
        for (int i = 0; i < 4; i++) sendc(8'(8'h10 + i), 1'b0);
        chk("R6 no overrun at full", 32'(overrun), 32'd0);
        sendc(8'h55, 1'b1);
        chk("R6 overrun set", 32'(overrun), 32'd1);
        for (int i = 0; i < 4; i++) pop("R6 kept", 8'(8'h10 + i), 1'b0, 1'b0);
        chk("R6 fifth discarded", 32'(rx_ready), 32'd0);
        chk("R6 still sticky", 32'(overrun), 32'd1);
        clr_err = 1'b1; @(posedge clk); #1; clr_err = 1'b0;
        chk("R6 cleared", 32'(overrun), 32'd0);
    endtask

    task automatic t_ovr_drop();
        rx_en = 1'b0;
        for (int i = 0; i < 4; i++) sendc(8'(8'h60 + i), 1'b1);
        sendc(8'h77, 1'b0);
        chk("R7 dropped char no overrun", 32'(overrun), 32'd0);
        for (int i = 0; i < 4; i++) pop("R7 kept", 8'(8'h60 + i), 1'b1, 1'b0);
        rx_en = 1'b1;
    endtask

    task automatic t_ferr();
        rx_en = 1'b1; two_stop = 1'b0;
        send(8'h81, 1'b0, 8, 1, 1'b0, 1'b1, 1'b0, 2'd0);
        chk("R8 no break on ferr", 32'(brk), 32'd0);
        pop("R8 stop low", 8'h81, 1'b0, 1'b1);
        two_stop = 1'b1;
        send(8'h7E, 1'b1, 8, 2, 1'b1, 1'b0, 1'b0, 2'd0);
        pop("R8 second stop low", 8'h7E, 1'b1, 1'b1);
        two_stop = 1'b0;
    endtask

    task automatic t_break();
        rx_en = 1'b1; len_sel = 2'd3; two_stop = 1'b0;
        hold(1'b0, 14 * BIT);
        chk("R9 brk high", 32'(brk), 32'd1);
        hold(1'b1, 8);
        chk("R9 brk cleared", 32'(brk), 32'd0);
        hold(1'b1, 2 * BIT);
        pop("R9 break entry", 8'h00, 1'b0, 1'b1);
        rx_en = 1'b0;
        hold(1'b0, 14 * BIT);
        chk("R9 brk high disabled", 32'(brk), 32'd1);
        chk("R9 break dropped disabled", 32'(rx_ready), 32'd0);
        hold(1'b1, 3 * BIT);
        rx_en = 1'b1;
    endtask

    task automatic t_cfg();
        len_sel = 2'd3; two_stop = 1'b0;
        send(8'hC3, 1'b1, 8, 1, 1'b1, 1'b1, 1'b1, 2'd0);
        pop("R10 mid-frame config ignored", 8'hC3, 1'b1, 1'b0);
        len_sel = 2'd3; two_stop = 1'b0;
    endtask

    task automatic t_false();
        hold(1'b0, BIT / 4);
        hold(1'b1, 3 * BIT);
        chk("R11 glitch ignored", 32'(rx_ready), 32'd0);
        sendc(8'h5A, 1'b0);
        pop("R11 next frame", 8'h5A, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_format();
        t_enabled();
        t_disabled();
        t_fifo();
        t_overrun();
        t_ovr_drop();
        t_ferr();
        t_break();
        t_cfg();
        t_false();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule